// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the sequence of column addresses that a synchronous DRAM controller puts on the bus, one per data beat. A request is a single-cycle start pulse that carries the first column, a read/write flag and the mode settings in force. The mode settings are a 3-bit length code, an ordering bit and a bit that forces writes to one beat. The block captures these settings when the burst starts. It then presents the first column. Each time the controller asserts the advance strobe, it steps to the next beat.

The column steps through the aligned block of the burst length. It counts upward and wraps in sequential ordering, or it XORs the beat number into the low bits in interleaved ordering. A flag marks the final beat. Full-page bursts run over the whole 256-column row and wrap. They never mark a final beat, so the controller ends them with the stop input. An unsupported length code gives a one-beat burst and sets a sticky error flag.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, valid_o, last_o and cfg_err_o are 0.
- R2: One cycle after start_i, valid_o is 1 and col_o equals the start column. A start while a burst is active abandons that burst and begins the new one.
- R3: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. last_o is 1 exactly on the final beat. An advance on the final beat makes valid_o 0 on the next cycle.
- R4: With order_ilv_i=0, beat n has col = (start with its low bits cleared) | ((start + n) mod L), where L is the burst length. The column counts up and wraps inside the aligned block of L columns.
- R5: With order_ilv_i=1, the low log2(L) bits of beat n are the start column's low bits XOR n. The upper bits are those of the start column.
- R6: Code 111 with order_ilv_i=0 is a full-page burst. The column is (start + n) mod 256, and last_o stays 0 for the whole burst.
- R7: stop_i during an active burst makes valid_o 0 on the next cycle, and stop_i takes priority over advance_i.
- R8: When wr_single_i=1, a write (is_write_i=1) is one beat regardless of the length code. Reads keep the coded length.
- R9: Codes 100, 101 and 110, and code 111 with order_ilv_i=1, are reserved. A start with a reserved code gives a one-beat burst and sets cfg_err_o, which stays 1 until reset.
- R10: While advance_i is 0, col_o and last_o hold. Changes to the mode inputs after the start cycle have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst; samples the column, direction and mode inputs |
| start_col_i | input | COL_W | First column of the burst |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| len_code_i | input | 3 | Burst length code |
| order_ilv_i | input | 1 | 0 = sequential ordering, 1 = interleaved ordering |
| wr_single_i | input | 1 | 1 = writes are single-beat |
| advance_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | Terminate the active burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one |
| cfg_err_o | output | 1 | Sticky flag: a reserved length code was used |

## Verification
Each beat's column is due one clock edge after the edge that captured the start or the advance that produced it. The end of a burst, whether from the final advance or from stop_i, shows as valid_o low one edge after that input. The driver changes inputs 1 ns after a rising edge. The monitor samples on the falling edge in the same cycle. As a result, each expected column queued by the driver is compared against exactly one presented beat. After every burst, the bench confirms at a falling edge that valid_o has dropped and that no expected beat is left over.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             is_write_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_ilv_i,
  input  logic             wr_single_i,
  input  logic             advance_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             cfg_err_o
);

  logic [COL_W-1:0] base_q, cnt_q, mask_q, mask_c, offs;
  logic             full_q, ilv_q;
  logic             code_full, code_rsvd, wr_one, full_c;

  assign code_full = &len_code_i;
  assign code_rsvd = (len_code_i[2] & ~code_full) | (code_full & order_ilv_i);
  assign wr_one    = is_write_i & wr_single_i;
  assign full_c    = code_full & ~order_ilv_i & ~wr_one;

  always_comb begin
    mask_c = '0;
    if (full_c)
      mask_c = '1;
    else if (!wr_one && !len_code_i[2])
      mask_c[2:0] = (3'b001 << len_code_i[1:0]) - 3'b001;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      cfg_err_o <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      mask_q    <= '0;
      full_q    <= 1'b0;
      ilv_q     <= 1'b0;
    end else if (start_i) begin
      valid_o   <= 1'b1;
      cfg_err_o <= cfg_err_o | code_rsvd;
      base_q    <= start_col_i;
      cnt_q     <= '0;
      mask_q    <= mask_c;
      full_q    <= full_c;
      ilv_q     <= order_ilv_i;
    end else if (valid_o) begin
      if (stop_i || (advance_i && last_o))
        valid_o <= 1'b0;
      else if (advance_i)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign offs   = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col_o  = (base_q & ~mask_q) | (offs & mask_q);
  assign last_o = valid_o & ~full_q & (cnt_q == mask_q);

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             is_write_i,
  input logic [2:0]       len_code_i,
  input logic             order_ilv_i,
  input logic             wr_single_i,
  input logic             advance_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             cfg_err_o
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && col_o == $past(start_col_i));

  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R3
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && last_o && advance_i && !start_i |=> !valid_o);

  // R6
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && len_code_i == 3'b111 && !order_ilv_i && !(is_write_i && wr_single_i) |=> !last_o);

  // R7
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && stop_i && !start_i |=> !valid_o);

  // R8
  wr_one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && is_write_i && wr_single_i |=> last_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !advance_i && !start_i && !stop_i |=> valid_o && $stable(col_o) && $stable(last_o));

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/sdram_burst_colgen_tb.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, is_write_i = 1'b0, order_ilv_i = 1'b0, wr_single_i = 1'b0;
  logic advance_i = 1'b0, stop_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [7:0] col_o;
  logic valid_o, last_o, cfg_err_o;

  int errors = 0, checks = 0;
  logic [8:0] exp_q[$];
  string      req_q[$];

  always #2.5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(8)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_beat(input logic [7:0] col, input int k, input logic [2:0] code,
                                          input logic ilv, input logic wr, input logic ws);
    logic [7:0] m, o;
    logic full;
    full = (code == 3'b111) && !ilv && !(wr && ws);
    if (full) m = 8'hFF;
    else if ((wr && ws) || code[2]) m = 8'h00;
    else m = 8'((1 << code[1:0]) - 1);
    o = (ilv && !full) ? (col ^ 8'(k)) : (col + 8'(k));
    return {!full && (8'(k) == m), (col & ~m) | (o & m)};
  endfunction

  function automatic int blen(input logic [2:0] code, input logic ilv, input logic wr, input logic ws);
    if (wr && ws) return 1;
    if (code == 3'b111) return ilv ? 1 : 256;
    if (code[2]) return 1;
    return 1 << code[1:0];
  endfunction

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0)
        chk(0, "R3", "unexpected beat col", int'(col_o), 0);
      else begin
        automatic logic [8:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk({last_o, col_o} == e, r, "beat {last,col}", int'({last_o, col_o}), int'(e));
      end
    end
  end

  task automatic run(input string req, input logic [7:0] col, input logic wr, input logic [2:0] code,
                     input logic ilv, input logic ws, input int hold, input int nstop);
    int n = nstop > 0 ? nstop : blen(code, ilv, wr, ws);
    for (int h = 0; h < hold; h++) begin
      exp_q.push_back(exp_beat(col, 0, code, ilv, wr, ws));
      req_q.push_back("R10");
    end
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(exp_beat(col, k, code, ilv, wr, ws));
      req_q.push_back(req);
    end
    start_i = 1; start_col_i = col; is_write_i = wr; len_code_i = code;
    order_ilv_i = ilv; wr_single_i = ws; advance_i = (hold == 0);
    @(posedge clk); #1;
    // R10: scramble mode inputs after the start cycle
    start_i = 0; len_code_i = ~code; order_ilv_i = ~ilv; wr_single_i = ~ws;
    is_write_i = ~wr; start_col_i = ~col;
    if (hold > 0) begin
      repeat (hold) @(posedge clk);
      #1 advance_i = 1;
    end
    if (nstop > 0) begin
      repeat (n - 1) @(posedge clk);
      #1 stop_i = 1;
      @(posedge clk); #1 stop_i = 0;
    end else begin
      repeat (n) @(posedge clk);
      #1;
    end
    @(negedge clk);
    chk(!valid_o, req, "valid after burst end", int'(valid_o), 0);
    chk(exp_q.size() == 0, req, "missing beats", exp_q.size(), 0);
    exp_q.delete(); req_q.delete();
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!valid_o && !last_o && !cfg_err_o, "R1", "reset outputs", int'({valid_o, last_o, cfg_err_o}), 0);

    run("R3", 8'h37, 0, 3'b000, 0, 0, 0, 0);
    run("R4", 8'h37, 0, 3'b001, 0, 0, 0, 0);
    run("R4", 8'h26, 0, 3'b010, 0, 0, 0, 0);
    run("R4", 8'h7D, 0, 3'b011, 0, 0, 0, 0);
    run("R5", 8'h7D, 0, 3'b011, 1, 0, 0, 0);
    run("R5", 8'h12, 1, 3'b010, 1, 0, 0, 0);
    run("R6", 8'hF0, 0, 3'b111, 0, 0, 0, 260);
    run("R7", 8'h44, 0, 3'b011, 0, 0, 0, 3);
    run("R8", 8'h50, 1, 3'b011, 0, 1, 0, 0);
    run("R8", 8'h50, 0, 3'b010, 0, 1, 0, 0);
    run("R8", 8'h51, 1, 3'b010, 0, 0, 0, 0);
    run("R10", 8'h05, 0, 3'b010, 0, 0, 2, 0);
    @(negedge clk);
    chk(!cfg_err_o, "R9", "error before reserved code", int'(cfg_err_o), 0);
    run("R9", 8'h66, 0, 3'b101, 0, 0, 0, 0);
    chk(cfg_err_o, "R9", "error after code 101", int'(cfg_err_o), 1);
    run("R9", 8'h67, 0, 3'b111, 1, 0, 0, 0);
    run("R9", 8'h68, 0, 3'b010, 0, 0, 0, 0);
    chk(cfg_err_o, "R9", "error stays set", int'(cfg_err_o), 1);

    // R2: restart a len-8 burst after two beats with a len-4 interleaved burst
    exp_q.push_back(exp_beat(8'h40, 0, 3'b011, 0, 0, 0)); req_q.push_back("R2");
    exp_q.push_back(exp_beat(8'h40, 1, 3'b011, 0, 0, 0)); req_q.push_back("R2");
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(exp_beat(8'h93, k, 3'b010, 1, 0, 0)); req_q.push_back("R2");
    end
    start_i = 1; start_col_i = 8'h40; is_write_i = 0; len_code_i = 3'b011;
    order_ilv_i = 0; wr_single_i = 0; advance_i = 1;
    @(posedge clk); #1 start_i = 0;
    @(posedge clk); #1 start_i = 1; start_col_i = 8'h93; len_code_i = 3'b010; order_ilv_i = 1;
    @(posedge clk); #1 start_i = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!valid_o, "R2", "valid after restarted burst", int'(valid_o), 0);
    chk(exp_q.size() == 0, "R2", "missing beats", exp_q.size(), 0);

    #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!cfg_err_o && !valid_o, "R1", "error cleared by reset", int'({cfg_err_o, valid_o}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule